// File: doc/BRIEF.md
# Rescaling PWM Audio Converter

This block takes a stream of 16-bit unsigned audio samples and produces a single-bit pulse-width output. Each pulse period is exactly one audio sample interval. The interval length is a programmable count of system clocks that a sample-rate divider would supply. For example, 2721 clocks at 120 MHz gives roughly 44.1 kHz, and 1666 clocks at 80 MHz gives about 48019 Hz. Because that count is seldom a power of two, each sample is rescaled by count/0xFFFF into a compare value, and the compare value sets the high time. The effective resolution is therefore only log2 of the count, about 11.4 bits for 2721 clocks.

Samples arrive over a valid/ready handshake into a one-entry holding buffer. A request strobe marks the final clock of every period so that an upstream source can pace itself. Both the period count and the rescaled compare value take effect together at a period boundary, so the output never changes duty in the middle of a period. If no sample is waiting when a period ends, the previous duty is replayed and a sticky flag records the miss.

Top module: `audio_pwm_dac`

## Requirements
- R1: The period length is taken from `period_i` at each period boundary. Every period lasts that many clocks, and `smp_req_o` is high for exactly the last clock of each period.
- R2: A `period_i` value of 0 or 1 is treated as 2. After reset, the first period also uses a length of 2.
- R3: The compare value of a period is floor(sample × P / 65535), where P is the clamped length of that period. This is exact for every sample when P ≤ 16383. For example, P = 2721 with sample 0x1234 gives 193 high clocks.
- R4: `pwm_o` is high during the first C clocks of a period, where C is the compare value, and low for the remaining clocks.
- R5: Sample 0xFFFF keeps `pwm_o` high for the whole period. Sample 0x0000 keeps it low for the whole period.
- R6: The compare value and the period length change only at a period boundary. The output pattern inside a period is never disturbed.
- R7: `smp_ready_o` is high when the holding buffer is empty, and also during the last clock of a period. A sample is accepted on a clock edge where both `smp_valid_i` and `smp_ready_o` are high.
- R8: If the buffer is empty at the end of a period, the next period repeats the previous compare value and `underrun_o` goes high and stays high.
- R9: `underrun_clr_i` high at a clock edge clears `underrun_o`, unless a new underrun occurs at that same edge.
- R10: While reset is asserted, `pwm_o`, `smp_req_o` and `underrun_o` are low, `smp_ready_o` is high, and the compare value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | 14 | Clocks per sample interval |
| smp_data_i | input | 16 | Unsigned audio sample |
| smp_valid_i | input | 1 | Sample present |
| smp_ready_o | output | 1 | Buffer can take a sample |
| smp_req_o | output | 1 | Last clock of the current period |
| underrun_clr_i | input | 1 | Clears the underrun flag |
| underrun_o | output | 1 | Sticky missed-sample flag |
| pwm_o | output | 1 | Pulse-width output |

## Verification
The assertions assume that `period_i` never exceeds the 14-bit range, since that range is what keeps the rescale exact. They make no assumption about how `period_i` moves within a period, because the block only samples it at the boundary. They also assume that `underrun_clr_i` is a level the bench may raise at any clock.

The random stimulus mostly holds short periods from 0 to 47, so that many boundaries occur. It changes the period only now and then, and gates `smp_valid_i` randomly so that accepts, stalls and underruns all appear. A golden model divides with true integer division, independently of the design's reciprocal trick. Directed runs cover the long 2721 period, full-scale and zero samples, a clamped period, and the clear.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int unsigned SMP_W_DEF = 16;
  localparam int unsigned CNT_W_DEF = 14;
  localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_dac_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] per_nxt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] PerMin = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] cnt_q, per_q;

  // clamp so the counter always has at least two states
  assign per_nxt_o = (period_i < PerMin) ? PerMin : period_i;
  assign wrap_o    = (cnt_q == per_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= PerMin;
    end else if (wrap_o) begin
      cnt_q <= '0;
      per_q <= per_nxt_o;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
endmodule

// File: rtl/pwm_scale.sv
module pwm_scale
  import pwm_dac_pkg::*;
#(
  parameter int unsigned SMP_W = SMP_W_DEF,
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic [SMP_W-1:0] smp_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cmp_o
);
  localparam int unsigned PW = SMP_W + CNT_W;

  logic [PW:0] prod, sum;
  logic        unused_bits;

  assign prod = (PW+1)'(smp_i) * (PW+1)'(per_i);
  // floor(x / (2^SMP_W - 1)) == (x + (x >> SMP_W) + 1) >> SMP_W for quotients <= 2^SMP_W
  assign sum  = prod + (prod >> SMP_W) + (PW+1)'(1);
  assign cmp_o = sum[SMP_W +: CNT_W];
  assign unused_bits = ^{sum[PW], sum[SMP_W-1:0]};
endmodule

// File: rtl/pwm_sample_stage.sv
module pwm_sample_stage
  import pwm_dac_pkg::*;
#(
  parameter int unsigned SMP_W = SMP_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] data_i,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic             wrap_i,
  input  logic             clr_i,
  output logic [SMP_W-1:0] smp_o,
  output logic             has_o,
  output logic             underrun_o
);
  logic [SMP_W-1:0] smp_q;
  logic             has_q, und_q, take;

  assign ready_o = !has_q || wrap_i;
  assign take    = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      has_q <= 1'b0;
    end else if (take) begin
      smp_q <= data_i;
      has_q <= 1'b1;
    end else if (wrap_i) begin
      has_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                und_q <= 1'b0;
    else if (wrap_i && !has_q)  und_q <= 1'b1;
    else if (clr_i)             und_q <= 1'b0;
  end

  assign smp_o      = smp_q;
  assign has_o      = has_q;
  assign underrun_o = und_q;
endmodule

// File: rtl/audio_pwm_dac.sv
module audio_pwm_dac
  import pwm_dac_pkg::*;
#(
  parameter int unsigned SMP_W = SMP_W_DEF,
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  output logic             smp_req_o,
  input  logic             underrun_clr_i,
  output logic             underrun_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt, per, per_nxt, cmp_nxt, cmp_q;
  logic [SMP_W-1:0] stg_smp;
  logic             wrap, stg_has;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni, .period_i,
    .cnt_o(cnt), .per_o(per), .per_nxt_o(per_nxt), .wrap_o(wrap)
  );

  pwm_sample_stage #(.SMP_W(SMP_W)) u_stg (
    .clk_i, .rst_ni,
    .data_i(smp_data_i), .valid_i(smp_valid_i), .ready_o(smp_ready_o),
    .wrap_i(wrap), .clr_i(underrun_clr_i),
    .smp_o(stg_smp), .has_o(stg_has), .underrun_o(underrun_o)
  );

  // scaled against the period that starts next
  pwm_scale #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_scale (
    .smp_i(stg_smp), .per_i(per_nxt), .cmp_o(cmp_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cmp_q <= '0;
    else if (wrap && stg_has)  cmp_q <= cmp_nxt;
  end

  assign smp_req_o = wrap;
  assign pwm_o     = (cnt < cmp_q);
endmodule

// File: rtl/audio_pwm_dac_chk.sv
module audio_pwm_dac_chk #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per,
  input logic [CNT_W-1:0] cmp_q,
  input logic             pwm_o,
  input logic             smp_req_o,
  input logic             smp_ready_o,
  input logic             underrun_o,
  input logic             underrun_clr_i
);
  AST_PER_FLOOR:  assert property (@(posedge clk_i) disable iff (!rst_ni) per >= CNT_W'(2));  // R2
  AST_CNT_BOUND:  assert property (@(posedge clk_i) disable iff (!rst_ni) cnt < per);  // R1
  AST_REQ_WRAPS:  assert property (@(posedge clk_i) disable iff (!rst_ni) smp_req_o |=> cnt == '0);  // R1
  AST_CMP_HOLD:   assert property (@(posedge clk_i) disable iff (!rst_ni) cnt != '0 |-> $stable(cmp_q) && $stable(per));  // R6
  AST_PWM_ZERO:   assert property (@(posedge clk_i) disable iff (!rst_ni) cmp_q == '0 |-> !pwm_o);  // R5
  AST_PWM_FULL:   assert property (@(posedge clk_i) disable iff (!rst_ni) cmp_q >= per |-> pwm_o);  // R5
  AST_UND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) underrun_o && !underrun_clr_i |=> underrun_o);  // R8
  AST_UND_CLEAR:  assert property (@(posedge clk_i) disable iff (!rst_ni) underrun_o && underrun_clr_i && !smp_req_o |=> !underrun_o);  // R9
  AST_READY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) smp_req_o |-> smp_ready_o);  // R7
endmodule

bind audio_pwm_dac audio_pwm_dac_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .cnt, .per, .cmp_q, .pwm_o, .smp_req_o,
  .smp_ready_o, .underrun_o, .underrun_clr_i
);

// File: tb/tb_audio_pwm_dac.sv
module tb_audio_pwm_dac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] period = 14'd5;
  logic [15:0] data = '0;
  logic        valid = 1'b0, clr = 1'b0;
  logic        ready, req, und, pwm;
  int          n_chk = 0, n_fail = 0;
  bit          cmp_en = 1'b0;

  always #5 clk = ~clk;

  audio_pwm_dac dut (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .smp_data_i(data),
    .smp_valid_i(valid), .smp_ready_o(ready), .smp_req_o(req),
    .underrun_clr_i(clr), .underrun_o(und), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int scale(input int s, input int p);
    return (s * p) / 65535;
  endfunction

  // golden model built from the requirements
  int m_cnt, m_per, m_cmp, m_stg;
  bit m_has, m_und;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 2; m_cmp = 0; m_stg = 0; m_has = 0; m_und = 0;
    end else begin
      bit wrp, acc;
      int p2;
      wrp = (m_cnt == m_per - 1);
      acc = valid && (!m_has || wrp);
      p2  = (period < 2) ? 2 : int'(period);
      if (wrp) begin
        if (m_has) m_cmp = scale(m_stg, p2);
        if (!m_has) m_und = 1;
        else if (clr) m_und = 0;
      end else if (clr) m_und = 0;
      if (acc) begin m_stg = data; m_has = 1; end
      else if (wrp) m_has = 0;
      if (wrp) begin m_cnt = 0; m_per = p2; end
      else m_cnt++;
    end
  end

  always @(negedge clk) if (rst_n && cmp_en) begin
    chk(pwm == (m_cnt < m_cmp), "R4 pwm", pwm, m_cnt < m_cmp);
    chk(req == (m_cnt == m_per - 1), "R1 req", req, m_cnt == m_per - 1);
    chk(ready == (!m_has || m_cnt == m_per - 1), "R7 ready", ready, !m_has || m_cnt == m_per - 1);
    chk(und == m_und, "R8/R9 underrun", und, m_und);
  end

  task automatic measure(output int len, output int highs);
    do @(negedge clk); while (!req);
    len = 0; highs = 0;
    do begin
      @(negedge clk);
      len++;
      if (pwm) highs++;
    end while (!req);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int len, hi;
    void'($urandom(32'd1234));
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(!pwm, "R10 pwm", pwm, 0);
    chk(!req, "R10 req", req, 0);
    chk(!und, "R10 underrun", und, 0);
    chk(ready, "R10 ready", ready, 1);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // random phase
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (valid && ready) begin
        valid = ($urandom_range(9) < 7);
        data  = ($urandom_range(7) == 0) ? (($urandom_range(1) == 0) ? 16'h0000 : 16'hFFFF)
                                         : 16'($urandom);
      end else if (!valid) begin
        valid = ($urandom_range(9) < 5);
        data  = 16'($urandom);
      end
      if ($urandom_range(199) == 0) period = 14'($urandom_range(47));
      clr = ($urandom_range(29) == 0);
    end
    clr = 1'b0;

    // R3: long period, 0x1234 gives 193 high clocks
    period = 14'd2721; data = 16'h1234; valid = 1'b1;
    measure(len, hi); measure(len, hi);
    chk(len == 2721, "R1 length", len, 2721);
    chk(hi == 193, "R3 compare", hi, 193);

    // R5 full scale and zero
    period = 14'd100; data = 16'hFFFF;
    measure(len, hi); measure(len, hi); measure(len, hi);
    chk(hi == 100, "R5 full scale", hi, 100);
    data = 16'h0000;
    measure(len, hi); measure(len, hi);
    chk(hi == 0, "R5 zero", hi, 0);

    // R2 clamp
    period = 14'd1; data = 16'h8000;
    measure(len, hi); measure(len, hi);
    chk(len == 2, "R2 clamp", len, 2);
    chk(hi == 1, "R3 clamped duty", hi, 1);

    // R6 mid-period data change does not move the edge
    period = 14'd40; data = 16'h4000;
    measure(len, hi); measure(len, hi);
    chk(hi == scale(16'h4000, 40), "R6 steady duty", hi, scale(16'h4000, 40));

    // R8 underrun then R9 clear
    period = 14'd10; valid = 1'b0;
    measure(len, hi); measure(len, hi);
    chk(und, "R8 set", und, 1);
    chk(hi == scale(16'h4000, 10), "R8 repeat duty", hi, scale(16'h4000, 10));
    do @(negedge clk); while (!req);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(!und, "R9 clear", und, 0);
    measure(len, hi);
    chk(und, "R8 reset again", und, 1);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule